// File: doc/BRIEF.md
# Integer Execution Unit with Status Flags

This block is the integer datapath of a small 32-bit RISC core. Each cycle it takes two source operands and an operation code and presents the result combinationally, together with a write-enable for the destination register and an exception strobe. Two status bits are kept inside the block: a carry bit (CY) and a compare flag (F). They update on the rising clock edge when the operation is accompanied by a valid strobe.

The supported operations are:

- add, add-with-carry, subtract and multiply (low word);
- signed and unsigned divide;
- AND, OR and XOR;
- logical left, logical right and arithmetic right shift;
- a load of the upper half from an immediate;
- byte and halfword sign or zero extension;
- a flag-driven conditional select;
- a search for the lowest set bit;
- ten set-flag comparisons.

A zero divisor suppresses the register write and raises an illegal-instruction exception instead. The operation codes are the values of the package enumeration `exu_op_e`.

Top module: `int_exec_unit`

## Requirements
- R1: Add yields A+B, add-with-carry yields A+B+CY, subtract yields A-B and multiply yields the low 32 bits of A*B; all wrap modulo 2^32.
- R2: After a valid add or add-with-carry, CY becomes 1 exactly when the unsigned result is below the unsigned value of B, else 0; no other operation changes CY.
- R3: With parameter ARITH_FLAG at 1 (the default), a valid add, add-with-carry or AND sets F to 1 when the result is zero and to 0 otherwise.
- R4: Signed or unsigned divide with B equal to zero drives exc_o high and wr_o low, and leaves CY and F unchanged.
- R5: The load-upper operation returns B[15:0] in bits 31:16 and zeros in bits 15:0.
- R6: The comparisons (equal, not-equal, and greater, greater-or-equal, less, less-or-equal in both signed and unsigned forms) write only F; wr_o stays low and CY is unchanged.
- R7: Conditional select returns A when F is 1 and B when F is 0.
- R8: The extend operations sign- or zero-extend A[7:0] or A[15:0] to 32 bits.
- R9: Find-first-one returns the 1-based position of the lowest set bit of A, and 0 when A is zero.
- R10: Shifts use only B[4:0] as the amount, and arithmetic right shift fills with A[31].
- R11: CY and F are zero after reset and change only on a clock edge where valid_i is high.
- R12: AND, OR and XOR return the bitwise result; OR and XOR leave F unchanged.
- R13: Signed divide truncates toward zero on two's-complement operands, and unsigned divide treats both operands as unsigned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| valid_i | input | 1 | Operation strobe; enables flag update, write and exception |
| op_i | input | 5 | Operation code (exu_op_e) |
| a_i | input | 32 | First source operand |
| b_i | input | 32 | Second source operand or immediate |
| result_o | output | 32 | Combinational result |
| wr_o | output | 1 | Destination write enable |
| exc_o | output | 1 | Illegal-instruction exception (zero divisor) |
| cy_o | output | 1 | Carry status bit |
| f_o | output | 1 | Compare flag status bit |

## Verification
The hardest situation to reach is add-with-carry consuming a carry that an earlier add produced. The CY value an add-with-carry sees depends on the history of the flags, and a carry-out of 1 needs a result that wraps below B. The stimulus therefore chains an all-ones plus one add, which sets CY and F, straight into an add-with-carry. It then clears CY with an add of zeros, and follows that with conditional selects after comparisons that force F both ways. The scoreboard models both flags so that every dependent result is predicted from the same history.

// File: rtl/exu_pkg.sv
package exu_pkg;
  typedef enum logic [4:0] {
    OP_ADD, OP_ADDC, OP_SUB, OP_MUL, OP_DIV, OP_DIVU,
    OP_AND, OP_OR, OP_XOR,
    OP_SLL, OP_SRL, OP_SRA,
    OP_MOVHI, OP_EXTBS, OP_EXTBZ, OP_EXTHS, OP_EXTHZ,
    OP_CMOV, OP_FF1,
    OP_SFEQ, OP_SFNE, OP_SFGTS, OP_SFGES, OP_SFLTS, OP_SFLES,
    OP_SFGTU, OP_SFGEU, OP_SFLTU, OP_SFLEU
  } exu_op_e;
endpackage

// File: rtl/exu_arith.sv
module exu_arith
  import exu_pkg::*;
#(
  parameter int W = 32
) (
  input  exu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           cy_in,
  output logic [W-1:0]   res,
  output logic           carry,
  output logic           div_zero
);
  logic [W-1:0] sum, safe_b, prod;
  logic         cin;

  assign cin      = (op == OP_ADDC) ? cy_in : 1'b0;
  assign sum      = a + b + {{(W-1){1'b0}}, cin};
  assign carry    = sum < b;
  assign div_zero = (b == '0);
  assign safe_b   = div_zero ? {{(W-1){1'b0}}, 1'b1} : b;
  assign prod     = a * b;

  always_comb begin
    unique case (op)
      OP_ADD, OP_ADDC: res = sum;
      OP_SUB:          res = a - b;
      OP_MUL:          res = prod;
      OP_DIV:          res = div_zero ? '0 : W'($signed(a) / $signed(safe_b));
      OP_DIVU:         res = div_zero ? '0 : a / safe_b;
      default:         res = '0;
    endcase
  end
endmodule

// File: rtl/exu_bitops.sv
module exu_bitops
  import exu_pkg::*;
#(
  parameter int W = 32
) (
  input  exu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           f_in,
  output logic [W-1:0]   res
);
  localparam int HALF = W / 2;
  localparam int SHW  = $clog2(W);
  localparam int IXW  = SHW + 1;

  logic [SHW-1:0] sh;
  logic [IXW-1:0] ff_idx;

  assign sh = b[SHW-1:0];

  always_comb begin
    ff_idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (a[i]) ff_idx = IXW'(i + 1);
    end
  end

  always_comb begin
    unique case (op)
      OP_AND:   res = a & b;
      OP_OR:    res = a | b;
      OP_XOR:   res = a ^ b;
      OP_SLL:   res = a << sh;
      OP_SRL:   res = a >> sh;
      OP_SRA:   res = W'($signed(a) >>> sh);
      OP_MOVHI: res = {b[HALF-1:0], {HALF{1'b0}}};
      OP_EXTBS: res = {{(W-8){a[7]}}, a[7:0]};
      OP_EXTBZ: res = {{(W-8){1'b0}}, a[7:0]};
      OP_EXTHS: res = {{HALF{a[HALF-1]}}, a[HALF-1:0]};
      OP_EXTHZ: res = {{HALF{1'b0}}, a[HALF-1:0]};
      OP_CMOV:  res = f_in ? a : b;
      OP_FF1:   res = W'(ff_idx);
      default:  res = '0;
    endcase
  end
endmodule

// File: rtl/exu_compare.sv
module exu_compare
  import exu_pkg::*;
#(
  parameter int W = 32
) (
  input  exu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic           is_cmp,
  output logic           hit
);
  logic eq, lts, ltu;

  assign eq  = (a == b);
  assign lts = $signed(a) < $signed(b);
  assign ltu = a < b;

  always_comb begin
    is_cmp = 1'b1;
    unique case (op)
      OP_SFEQ:  hit = eq;
      OP_SFNE:  hit = !eq;
      OP_SFGTS: hit = !lts && !eq;
      OP_SFGES: hit = !lts;
      OP_SFLTS: hit = lts;
      OP_SFLES: hit = lts || eq;
      OP_SFGTU: hit = !ltu && !eq;
      OP_SFGEU: hit = !ltu;
      OP_SFLTU: hit = ltu;
      OP_SFLEU: hit = ltu || eq;
      default: begin
        is_cmp = 1'b0;
        hit    = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import exu_pkg::*;
#(
  parameter int W          = 32,
  parameter bit ARITH_FLAG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid_i,
  input  logic [4:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] result_o,
  output logic         wr_o,
  output logic         exc_o,
  output logic         cy_o,
  output logic         f_o
);
  exu_op_e      op;
  logic [W-1:0] arith_res, bit_res;
  logic         carry, div_zero, is_cmp, hit;
  logic         is_arith, is_div, is_addx, zero_upd;
  logic         cy_q, f_q, cy_nx, f_nx;
  logic         rst_meta, rst_sync;

  assign op = exu_op_e'(op_i);

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  exu_arith #(.W(W)) u_arith (
    .op(op), .a(a_i), .b(b_i), .cy_in(cy_q),
    .res(arith_res), .carry(carry), .div_zero(div_zero)
  );

  exu_bitops #(.W(W)) u_bits (
    .op(op), .a(a_i), .b(b_i), .f_in(f_q), .res(bit_res)
  );

  exu_compare #(.W(W)) u_cmp (
    .op(op), .a(a_i), .b(b_i), .is_cmp(is_cmp), .hit(hit)
  );

  assign is_addx = (op == OP_ADD) || (op == OP_ADDC);
  assign is_div  = (op == OP_DIV) || (op == OP_DIVU);
  assign is_arith = is_addx || is_div || (op == OP_SUB) || (op == OP_MUL);
  assign zero_upd = ARITH_FLAG && (is_addx || (op == OP_AND));

  always_comb begin
    if (is_cmp)        result_o = '0;
    else if (is_arith) result_o = arith_res;
    else               result_o = bit_res;
  end

  assign exc_o = valid_i && is_div && div_zero;
  assign wr_o  = valid_i && !is_cmp && !(is_div && div_zero);

  // status next state
  always_comb begin
    cy_nx = cy_q;
    f_nx  = f_q;
    if (valid_i) begin
      if (is_addx)  cy_nx = carry;
      if (zero_upd) f_nx  = (result_o == '0);
      if (is_cmp)   f_nx  = hit;
    end
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      cy_q <= 1'b0;
      f_q  <= 1'b0;
    end else if (valid_i) begin
      cy_q <= cy_nx;
      f_q  <= f_nx;
    end
  end

  assign cy_o = cy_q;
  assign f_o  = f_q;

  // R4: a zero-divisor exception never coexists with a write
  a_r4_no_write_on_exc: assert property (@(posedge clk) disable iff (!rst_sync)
    exc_o |-> !wr_o);

  // R2: carry after an add reflects the wrapped result against B
  a_r2_carry_rule: assert property (@(posedge clk) disable iff (!rst_sync)
    (valid_i && op == OP_ADD) |=> (cy_o == ($past(result_o) < $past(b_i))));

  // R6: comparisons leave carry alone and never write
  a_r6_cmp_keeps_cy: assert property (@(posedge clk) disable iff (!rst_sync)
    (valid_i && is_cmp) |=> $stable(cy_o));

  a_r6_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_sync)
    (valid_i && is_cmp) |-> !wr_o);

  // R11: status holds without a valid strobe
  a_r11_hold_idle: assert property (@(posedge clk) disable iff (!rst_sync)
    !valid_i |=> ($stable(cy_o) && $stable(f_o)));

  // R5: load-upper clears the low half
  a_r5_movhi_low: assert property (@(posedge clk) disable iff (!rst_sync)
    (op == OP_MOVHI) |-> (result_o[W/2-1:0] == '0));
endmodule

// File: tb/int_exec_unit_test.sv
module int_exec_unit_test;
  import exu_pkg::*;

  typedef struct {
    logic [31:0] res;
    logic        chk_res;
    logic        wr;
    logic        exc;
    logic        cy;
    logic        f;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [4:0]  op_i = '0;
  logic [31:0] a_i = '0, b_i = '0;
  logic [31:0] result_o;
  logic        wr_o, exc_o, cy_o, f_o;

  int checks = 0;
  int fails  = 0;
  logic m_cy = 1'b0, m_f = 1'b0;
  exp_t q[$];

  always #10 clk = ~clk;

  int_exec_unit uut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .result_o(result_o), .wr_o(wr_o),
    .exc_o(exc_o), .cy_o(cy_o), .f_o(f_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ff1_model(input logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return 32'(i + 1);
    return 32'd0;
  endfunction

  // driver: apply one operation, predict outputs, queue prediction
  task automatic drive(input string tag, input logic v, input exu_op_e op,
                       input logic [31:0] a, input logic [31:0] b);
    exp_t e;
    logic [31:0] r;
    logic [4:0] s;
    bit cmp, hit;
    @(negedge clk);
    valid_i = v; op_i = 5'(op); a_i = a; b_i = b;
    s = b[4:0];
    cmp = 0; hit = 0; r = '0;
    case (op)
      OP_ADD:   r = a + b;
      OP_ADDC:  r = a + b + 32'(m_cy);
      OP_SUB:   r = a - b;
      OP_MUL:   r = a * b;
      OP_DIV:   r = (b == 0) ? 32'd0 : 32'($signed(a) / $signed(b));
      OP_DIVU:  r = (b == 0) ? 32'd0 : a / b;
      OP_AND:   r = a & b;
      OP_OR:    r = a | b;
      OP_XOR:   r = a ^ b;
      OP_SLL:   r = a << s;
      OP_SRL:   r = a >> s;
      OP_SRA:   r = 32'($signed(a) >>> s);
      OP_MOVHI: r = {b[15:0], 16'h0};
      OP_EXTBS: r = {{24{a[7]}}, a[7:0]};
      OP_EXTBZ: r = {24'h0, a[7:0]};
      OP_EXTHS: r = {{16{a[15]}}, a[15:0]};
      OP_EXTHZ: r = {16'h0, a[15:0]};
      OP_CMOV:  r = m_f ? a : b;
      OP_FF1:   r = ff1_model(a);
      OP_SFEQ:  begin cmp = 1; hit = (a == b); end
      OP_SFNE:  begin cmp = 1; hit = (a != b); end
      OP_SFGTS: begin cmp = 1; hit = $signed(a) >  $signed(b); end
      OP_SFGES: begin cmp = 1; hit = $signed(a) >= $signed(b); end
      OP_SFLTS: begin cmp = 1; hit = $signed(a) <  $signed(b); end
      OP_SFLES: begin cmp = 1; hit = $signed(a) <= $signed(b); end
      OP_SFGTU: begin cmp = 1; hit = a >  b; end
      OP_SFGEU: begin cmp = 1; hit = a >= b; end
      OP_SFLTU: begin cmp = 1; hit = a <  b; end
      OP_SFLEU: begin cmp = 1; hit = a <= b; end
      default:  r = '0;
    endcase
    e.res = r;
    e.chk_res = !cmp;
    e.exc = v && (op == OP_DIV || op == OP_DIVU) && b == 0;
    e.wr  = v && !cmp && !e.exc;
    if (v) begin
      if (op == OP_ADD || op == OP_ADDC) m_cy = (r < b);
      if (op == OP_ADD || op == OP_ADDC || op == OP_AND) m_f = (r == 0);
      if (cmp) m_f = hit;
    end
    e.cy = m_cy;
    e.f  = m_f;
    e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: combinational outputs mid-cycle, flags after the edge
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #5;
      if (q.size() > 0) begin
        e = q.pop_front();
        if (e.chk_res) check({e.tag, " result"}, result_o, e.res);
        check({e.tag, " wr"}, 32'(wr_o), 32'(e.wr));
        check({e.tag, " exc"}, 32'(exc_o), 32'(e.exc));
        @(posedge clk);
        #5;
        check({e.tag, " cy"}, 32'(cy_o), 32'(e.cy));
        check({e.tag, " f"}, 32'(f_o), 32'(e.f));
      end
    end
  end

  initial begin
    #(20 * 5000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset cy", 32'(cy_o), 32'd0);
    check("R11 reset f", 32'(f_o), 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    drive("R1 add",            1, OP_ADD,  32'd5, 32'd7);
    drive("R2 R3 add wrap",    1, OP_ADD,  32'hFFFF_FFFF, 32'd1);
    drive("R1 R2 addc cin",    1, OP_ADDC, 32'd1, 32'd2);
    drive("R2 R3 add zero",    1, OP_ADD,  32'd0, 32'd0);
    drive("R1 addc no cin",    1, OP_ADDC, 32'h8000_0000, 32'h8000_0000);
    drive("R1 addc after cy",  1, OP_ADDC, 32'd3, 32'd4);
    drive("R1 sub",            1, OP_SUB,  32'd3, 32'd5);
    drive("R1 mul",            1, OP_MUL,  32'd7, 32'hFFFF_FFFD);
    drive("R3 R12 and zero",   1, OP_AND,  32'hF0, 32'h0F);
    drive("R12 or keeps f",    1, OP_OR,   32'hF0, 32'h0F);
    drive("R12 xor",           1, OP_XOR,  32'hFF00, 32'h0FF0);
    drive("R3 and nonzero",    1, OP_AND,  32'hFF, 32'h18);
    drive("R13 div signed",    1, OP_DIV,  32'hFFFF_FFF9, 32'd2);
    drive("R13 divu",          1, OP_DIVU, 32'hFFFF_FFF9, 32'd2);
    drive("R4 div zero",       1, OP_DIV,  32'd9, 32'd0);
    drive("R4 divu zero",      1, OP_DIVU, 32'd9, 32'd0);
    drive("R10 sll low5",      1, OP_SLL,  32'd1, 32'd33);
    drive("R10 srl",           1, OP_SRL,  32'h8000_0000, 32'd4);
    drive("R10 sra fill",      1, OP_SRA,  32'h8000_0000, 32'd4);
    drive("R10 sra pos",       1, OP_SRA,  32'h4000_0000, 32'd36);
    drive("R5 movhi",          1, OP_MOVHI, 32'hDEAD_BEEF, 32'h1234_ABCD);
    drive("R8 extbs",          1, OP_EXTBS, 32'h1234_5680, 32'd0);
    drive("R8 extbz",          1, OP_EXTBZ, 32'h1234_5680, 32'd0);
    drive("R8 exths",          1, OP_EXTHS, 32'h1234_8001, 32'd0);
    drive("R8 exthz",          1, OP_EXTHZ, 32'h1234_8001, 32'd0);
    drive("R9 ff1 zero",       1, OP_FF1,  32'd0, 32'd0);
    drive("R9 ff1 top",        1, OP_FF1,  32'h8000_0000, 32'd0);
    drive("R9 ff1 mid",        1, OP_FF1,  32'h0000_0F08, 32'd0);
    drive("R6 sfeq",           1, OP_SFEQ, 32'd4, 32'd4);
    drive("R7 cmov f1",        1, OP_CMOV, 32'hAAAA, 32'h5555);
    drive("R6 sfne",           1, OP_SFNE, 32'd4, 32'd4);
    drive("R7 cmov f0",        1, OP_CMOV, 32'hAAAA, 32'h5555);
    drive("R6 sfgts",          1, OP_SFGTS, 32'hFFFF_FFFF, 32'd1);
    drive("R6 sfgtu",          1, OP_SFGTU, 32'hFFFF_FFFF, 32'd1);
    drive("R6 sfges eq",       1, OP_SFGES, 32'd5, 32'd5);
    drive("R6 sflts",          1, OP_SFLTS, 32'hFFFF_FFFF, 32'd1);
    drive("R6 sfltu",          1, OP_SFLTU, 32'hFFFF_FFFF, 32'd1);
    drive("R6 sfles",          1, OP_SFLES, 32'd2, 32'd1);
    drive("R6 sfgeu",          1, OP_SFGEU, 32'd1, 32'hFFFF_FFFF);
    drive("R6 sfleu eq",       1, OP_SFLEU, 32'd9, 32'd9);
    drive("R2 set cy",         1, OP_ADD,  32'hFFFF_FFF0, 32'h20);
    drive("R6 cmp keeps cy",   1, OP_SFEQ, 32'd1, 32'd2);
    drive("R11 idle add",      0, OP_ADD,  32'd0, 32'd0);
    drive("R11 idle cmp",      0, OP_SFEQ, 32'd3, 32'd3);
    drive("R1 addc uses cy",   1, OP_ADDC, 32'd10, 32'd20);
    repeat (4) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule